// File: doc/BRIEF.md
# Video Memory Write FIFO Drain

This block buffers host data-port words on their way to three video memories: a byte-wide video RAM, a word-wide colour RAM and a word-wide vertical-scroll RAM. Up to four 16-bit words wait in a queue. A timing sequencer grants memory slots with a one-cycle strobe. Each granted slot lets the oldest word perform one memory access. The target memory comes from the low three bits of the current access code. A shared address pointer steps by a programmable increment each time a word finishes.

A word bound for video RAM takes two granted slots. The first slot writes the high byte at the pointer. The second writes the low byte at the pointer with bit 0 inverted. Only then does the word leave the queue. A grant that finds the queue empty sets a sticky flag, which the sequencer or host can use to tell that the memory bus was idle.

Top module: `vmem_wfifo`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `fifo_empty`=1, `fifo_full`=0, `push_ready`=1, `slot_unused`=0, all three write strobes are 0 and `cur_addr`=0. Reset discards queued words.
- R2: The queue holds four words. After four accepted pushes, `fifo_full`=1 and `push_ready`=0. A push offered while full is dropped. `push_ready` returns to 1 in the cycle after a word retires.
- R3: Only `access_code[2:0]` selects the operation: 1 is video RAM write, 3 is colour RAM write, 5 is vertical-scroll RAM write. The upper code bits are ignored.
- R4: Every write strobe and its address and data appear in the cycle after the granting `slot_grant` cycle. On the first grant of a video RAM word, `vram_we` pulses with `vram_addr`=pointer and `vram_wdata`=word[15:8]. The word stays queued and the pointer is unchanged.
- R5: On the second grant of that word, `vram_we` pulses with `vram_addr`=pointer XOR 1 and `vram_wdata`=word[7:0]. The word then retires and the pointer advances by `addr_inc`.
- R6: A colour RAM word writes the whole word with `cram_addr`=pointer[5:0] in one grant. It then retires and the pointer advances by `addr_inc`, wrapping modulo 2^16.
- R7: A vertical-scroll RAM word writes only when pointer[5:0] is below 40, with `vsram_addr`=pointer[5:0]. Otherwise no strobe is raised. In both cases the word retires and the pointer advances.
- R8: Any other operation code retires the head word with no write strobe and advances the pointer.
- R9: Words are written in the order they were pushed.
- R10: A grant while the queue is empty raises no strobe and sets `slot_unused`. The flag stays set until `unused_clr` is pulsed, and a set in the same cycle wins over a clear. A word pushed in the same cycle as a grant is not served by that grant.
- R11: `addr_load` replaces the pointer with `addr_value` and takes priority over an advance in the same cycle. An access granted in that cycle uses the old pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Host offers a data word |
| push_data | input | 16 | Data word |
| push_ready | output | 1 | Queue can accept a word |
| slot_grant | input | 1 | One memory slot granted this cycle |
| access_code | input | 6 | Current access code; low 3 bits decoded |
| addr_load | input | 1 | Load the address pointer |
| addr_value | input | 16 | Value for the pointer load |
| addr_inc | input | 8 | Pointer increment per retired word |
| unused_clr | input | 1 | Clear the unused-slot flag |
| cur_addr | output | 16 | Current address pointer |
| fifo_empty | output | 1 | No words queued |
| fifo_full | output | 1 | Four words queued |
| slot_unused | output | 1 | Sticky: a grant found the queue empty |
| vram_we | output | 1 | Video RAM byte write strobe |
| vram_addr | output | 16 | Video RAM byte address |
| vram_wdata | output | 8 | Video RAM byte data |
| cram_we | output | 1 | Colour RAM write strobe |
| cram_addr | output | 6 | Colour RAM word address |
| cram_wdata | output | 16 | Colour RAM data |
| vsram_we | output | 1 | Vertical-scroll RAM write strobe |
| vsram_addr | output | 6 | Vertical-scroll RAM word address |
| vsram_wdata | output | 16 | Vertical-scroll RAM data |

## Verification
One word is sent for each operation code, including codes with the upper bits set. This separates decoding on the low three bits from decoding on the whole code. Start addresses are chosen to tell the byte-swapped second video RAM write from the first, a scroll address just inside the 40-word range from one at its edge, and a pointer that wraps at 16 bits. A filled queue drained by back-to-back grants checks ordering and the dropped fifth push. A grant arriving together with a push, and a pointer load arriving together with a retire, check the same-cycle priorities.

// File: rtl/vwf_pkg.sv
package vwf_pkg;

    localparam int WORD_W = 16;

    localparam logic [2:0] CODE_VRAM_WR  = 3'd1;
    localparam logic [2:0] CODE_CRAM_WR  = 3'd3;
    localparam logic [2:0] CODE_VSRAM_WR = 3'd5;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              partial;
    } wf_entry_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_VRAM_HI,
        TGT_VRAM_LO,
        TGT_CRAM,
        TGT_VSRAM
    } wf_target_e;

    typedef struct packed {
        wf_target_e target;
        logic       retire;
        logic       mark_partial;
    } wf_action_t;

    // Decide what one granted slot does with the head word.
    function automatic wf_action_t plan_access(input logic [2:0] op,
                                               input logic       partial,
                                               input logic       vsram_hit);
        wf_action_t a;
        a.target       = TGT_NONE;
        a.retire       = 1'b1;
        a.mark_partial = 1'b0;
        case (op)
            CODE_VRAM_WR: begin
                if (!partial) begin
                    a.target       = TGT_VRAM_HI;
                    a.retire       = 1'b0;
                    a.mark_partial = 1'b1;
                end else begin
                    a.target = TGT_VRAM_LO;
                end
            end
            CODE_CRAM_WR:  a.target = TGT_CRAM;
            CODE_VSRAM_WR: if (vsram_hit) a.target = TGT_VSRAM;
            default: ;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/vwf_queue.sv
module vwf_queue
    import vwf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_value,
    input  logic              pop,
    input  logic              mark_partial,
    output wf_entry_t         head,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full
);

    wf_entry_t        slots [DEPTH];
    wf_entry_t        above [DEPTH];
    logic [CNT_W-1:0] wr_idx;

    // After a same-cycle pop, the new word lands one place nearer the head.
    assign wr_idx = count - CNT_W'(pop);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        wf_entry_t slot_q;

        if (g == DEPTH - 1) begin : g_last
            assign above[g] = '0;
        end else begin : g_inner
            assign above[g] = slots[g+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (push && wr_idx == CNT_W'(g)) begin
                slot_q <= '{value: push_value, partial: 1'b0};
            end else if (pop) begin
                slot_q <= above[g];
            end else if (mark_partial && (g == 0)) begin
                slot_q.partial <= 1'b1;
            end
        end

        assign slots[g] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + CNT_W'(push) - CNT_W'(pop);
    end

    assign head  = slots[0];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));

    a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (pop || mark_partial) |-> !empty);

    a_r4_partial_kept: assert property (@(posedge clk) disable iff (rst)
        (mark_partial && !pop) |=> head.partial);

endmodule

// File: rtl/vwf_access.sv
module vwf_access
    import vwf_pkg::*;
#(
    parameter int VSRAM_AW    = 6,
    parameter int VSRAM_WORDS = 40
) (
    input  logic [2:0]          op,
    input  logic                head_partial,
    input  logic [VSRAM_AW-1:0] addr_low,
    output wf_action_t          action
);

    logic vsram_hit;

    assign vsram_hit = (int'(addr_low) < VSRAM_WORDS);

    always_comb begin
        action = plan_access(op, head_partial, vsram_hit);
    end

endmodule

// File: rtl/vmem_wfifo.sv
module vmem_wfifo
    import vwf_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int ADDR_W      = 16,
    parameter int INC_W       = 8,
    parameter int CODE_W      = 6,
    parameter int CRAM_AW     = 6,
    parameter int VSRAM_AW    = 6,
    parameter int VSRAM_WORDS = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                push_valid,
    input  logic [WORD_W-1:0]   push_data,
    output logic                push_ready,
    input  logic                slot_grant,
    input  logic [CODE_W-1:0]   access_code,
    input  logic                addr_load,
    input  logic [ADDR_W-1:0]   addr_value,
    input  logic [INC_W-1:0]    addr_inc,
    input  logic                unused_clr,
    output logic [ADDR_W-1:0]   cur_addr,
    output logic                fifo_empty,
    output logic                fifo_full,
    output logic                slot_unused,
    output logic                vram_we,
    output logic [ADDR_W-1:0]   vram_addr,
    output logic [7:0]          vram_wdata,
    output logic                cram_we,
    output logic [CRAM_AW-1:0]  cram_addr,
    output logic [WORD_W-1:0]   cram_wdata,
    output logic                vsram_we,
    output logic [VSRAM_AW-1:0] vsram_addr,
    output logic [WORD_W-1:0]   vsram_wdata
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    wf_entry_t        head;
    wf_action_t       act;
    logic [CNT_W-1:0] occ;
    logic             push_fire;
    logic             serve;
    logic             pop;
    logic             mark;
    logic [ADDR_W-1:0] addr_q;
    logic             unused_q;
    logic             unused_code_hi;

    assign unused_code_hi = ^access_code[CODE_W-1:3];

    assign push_ready = !fifo_full;
    assign push_fire  = push_valid && push_ready;
    assign serve      = slot_grant && !fifo_empty;
    assign pop        = serve && act.retire;
    assign mark       = serve && act.mark_partial;

    vwf_queue #(.DEPTH(DEPTH)) u_queue (
        .clk          (clk),
        .rst          (rst),
        .push         (push_fire),
        .push_value   (push_data),
        .pop          (pop),
        .mark_partial (mark),
        .head         (head),
        .count        (occ),
        .empty        (fifo_empty),
        .full         (fifo_full)
    );

    vwf_access #(.VSRAM_AW(VSRAM_AW), .VSRAM_WORDS(VSRAM_WORDS)) u_access (
        .op           (access_code[2:0]),
        .head_partial (head.partial),
        .addr_low     (addr_q[VSRAM_AW-1:0]),
        .action       (act)
    );

    // Shared address pointer: a load beats the post-retire step.
    always_ff @(posedge clk) begin
        if (rst)            addr_q <= '0;
        else if (addr_load) addr_q <= addr_value;
        else if (pop)       addr_q <= addr_q + ADDR_W'(addr_inc);
    end

    always_ff @(posedge clk) begin
        if (rst)                          unused_q <= 1'b0;
        else if (slot_grant && fifo_empty) unused_q <= 1'b1;
        else if (unused_clr)              unused_q <= 1'b0;
    end

    // Registered memory write ports, valid the cycle after the grant.
    always_ff @(posedge clk) begin
        if (rst) begin
            vram_we     <= 1'b0;
            vram_addr   <= '0;
            vram_wdata  <= '0;
            cram_we     <= 1'b0;
            cram_addr   <= '0;
            cram_wdata  <= '0;
            vsram_we    <= 1'b0;
            vsram_addr  <= '0;
            vsram_wdata <= '0;
        end else begin
            vram_we     <= serve && (act.target == TGT_VRAM_HI || act.target == TGT_VRAM_LO);
            vram_addr   <= (act.target == TGT_VRAM_LO) ? (addr_q ^ ADDR_W'(1)) : addr_q;
            vram_wdata  <= (act.target == TGT_VRAM_LO) ? head.value[7:0] : head.value[15:8];
            cram_we     <= serve && (act.target == TGT_CRAM);
            cram_addr   <= addr_q[CRAM_AW-1:0];
            cram_wdata  <= head.value;
            vsram_we    <= serve && (act.target == TGT_VSRAM);
            vsram_addr  <= addr_q[VSRAM_AW-1:0];
            vsram_wdata <= head.value;
        end
    end

    assign cur_addr    = addr_q;
    assign slot_unused = unused_q;

    a_r3_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vram_we, cram_we, vsram_we}));

    a_r4_write_needs_grant: assert property (@(posedge clk) disable iff (rst)
        (vram_we || cram_we || vsram_we) |-> $past(slot_grant));

    a_r4_hi_keeps_addr: assert property (@(posedge clk) disable iff (rst)
        (serve && act.target == TGT_VRAM_HI && !addr_load) |=> (cur_addr == $past(cur_addr)));

    a_r7_vsram_in_range: assert property (@(posedge clk) disable iff (rst)
        vsram_we |-> (int'(vsram_addr) < VSRAM_WORDS));

    a_r10_idle_flags: assert property (@(posedge clk) disable iff (rst)
        (slot_grant && fifo_empty) |=> (slot_unused && !vram_we && !cram_we && !vsram_we));

    a_r2_occ_bound: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= DEPTH);

endmodule

// File: tb/tb_vmem_wfifo.sv
module tb_vmem_wfifo;

    localparam int CLK_P = 10;
    localparam int NROWS = 9;

    typedef struct packed {
        logic [5:0]  code;
        logic [15:0] addr;
        logic [7:0]  inc;
        logic [15:0] data;
        logic [1:0]  tgt;    // 0 none, 1 video RAM, 2 colour RAM, 3 scroll RAM
        logic [15:0] waddr1;
        logic [15:0] waddr2;
        logic [15:0] next;
    } row_t;

    localparam row_t ROWS [NROWS] = '{
        '{6'h01, 16'h1000, 8'd2, 16'hABCD, 2'd1, 16'h1000, 16'h1001, 16'h1002},
        '{6'h21, 16'h2345, 8'd1, 16'h1234, 2'd1, 16'h2345, 16'h2344, 16'h2346},
        '{6'h03, 16'h00C5, 8'd2, 16'h0EEE, 2'd2, 16'h0005, 16'h0000, 16'h00C7},
        '{6'h05, 16'h0126, 8'd2, 16'h0555, 2'd3, 16'h0026, 16'h0000, 16'h0128},
        '{6'h05, 16'h0028, 8'd2, 16'h0777, 2'd0, 16'h0000, 16'h0000, 16'h002A},
        '{6'h3D, 16'h0041, 8'd4, 16'h0999, 2'd3, 16'h0001, 16'h0000, 16'h0045},
        '{6'h00, 16'h0100, 8'd2, 16'h0AAA, 2'd0, 16'h0000, 16'h0000, 16'h0102},
        '{6'h07, 16'h0200, 8'd0, 16'h0BBB, 2'd0, 16'h0000, 16'h0000, 16'h0200},
        '{6'h0B, 16'hFFFF, 8'd1, 16'h0CCC, 2'd2, 16'h003F, 16'h0000, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_valid = 1'b0;
    logic [15:0] push_data = '0;
    logic        push_ready;
    logic        slot_grant = 1'b0;
    logic [5:0]  access_code = '0;
    logic        addr_load = 1'b0;
    logic [15:0] addr_value = '0;
    logic [7:0]  addr_inc = '0;
    logic        unused_clr = 1'b0;
    logic [15:0] cur_addr;
    logic        fifo_empty, fifo_full, slot_unused;
    logic        vram_we;
    logic [15:0] vram_addr;
    logic [7:0]  vram_wdata;
    logic        cram_we;
    logic [5:0]  cram_addr;
    logic [15:0] cram_wdata;
    logic        vsram_we;
    logic [5:0]  vsram_addr;
    logic [15:0] vsram_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    vmem_wfifo dut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .push_ready(push_ready), .slot_grant(slot_grant), .access_code(access_code),
        .addr_load(addr_load), .addr_value(addr_value), .addr_inc(addr_inc),
        .unused_clr(unused_clr), .cur_addr(cur_addr), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .slot_unused(slot_unused), .vram_we(vram_we),
        .vram_addr(vram_addr), .vram_wdata(vram_wdata), .cram_we(cram_we),
        .cram_addr(cram_addr), .cram_wdata(cram_wdata), .vsram_we(vsram_we),
        .vsram_addr(vsram_addr), .vsram_wdata(vsram_wdata)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        string tag;
        @(negedge clk);
        tick();
        // R1: state during reset
        check("R1 empty in reset", fifo_empty, 1);
        check("R1 ready in reset", push_ready, 1);
        rst = 1'b0;
        check("R1 full", fifo_full, 0);
        check("R1 unused", slot_unused, 0);
        check("R1 strobes", {vram_we, cram_we, vsram_we}, 0);
        check("R1 addr", cur_addr, 0);

        // Table walk: one word per row, R3..R8
        for (int i = 0; i < NROWS; i++) begin
            addr_load = 1'b1; addr_value = ROWS[i].addr;
            addr_inc = ROWS[i].inc; access_code = ROWS[i].code;
            tick();
            addr_load = 1'b0;
            push_valid = 1'b1; push_data = ROWS[i].data;
            tick();
            push_valid = 1'b0;
            slot_grant = 1'b1;
            tick();
            slot_grant = 1'b0;
            if (ROWS[i].tgt == 2'd1) begin
                check("R3 R4 vram_we hi", vram_we, 1);
                check("R4 vram hi addr", vram_addr, ROWS[i].waddr1);
                check("R4 vram hi data", vram_wdata, ROWS[i].data[15:8]);
                check("R4 addr held", cur_addr, ROWS[i].addr);
                check("R4 word kept", fifo_empty, 0);
                slot_grant = 1'b1;
                tick();
                slot_grant = 1'b0;
                check("R5 vram_we lo", vram_we, 1);
                check("R5 vram lo addr", vram_addr, ROWS[i].waddr2);
                check("R5 vram lo data", vram_wdata, ROWS[i].data[7:0]);
                check("R5 addr step", cur_addr, ROWS[i].next);
                check("R5 retired", fifo_empty, 1);
            end else begin
                tag = (ROWS[i].tgt == 2'd2) ? "R6" : ((ROWS[i].code[2:0] == 3'd5) ? "R7" : "R8");
                check({tag, " R3 vram_we"}, vram_we, 0);
                check({tag, " R3 cram_we"}, cram_we, (ROWS[i].tgt == 2'd2));
                check({tag, " R3 vsram_we"}, vsram_we, (ROWS[i].tgt == 2'd3));
                if (ROWS[i].tgt == 2'd2) begin
                    check("R6 cram addr", cram_addr, ROWS[i].waddr1);
                    check("R6 cram data", cram_wdata, ROWS[i].data);
                end
                if (ROWS[i].tgt == 2'd3) begin
                    check("R7 vsram addr", vsram_addr, ROWS[i].waddr1);
                    check("R7 vsram data", vsram_wdata, ROWS[i].data);
                end
                check({tag, " addr step"}, cur_addr, ROWS[i].next);
                check({tag, " retired"}, fifo_empty, 1);
            end
        end

        // R2 and R9: fill, overfill, drain in order
        addr_load = 1'b1; addr_value = 16'h0000; addr_inc = 8'd1; access_code = 6'h03;
        tick();
        addr_load = 1'b0;
        for (int k = 0; k < 4; k++) begin
            push_valid = 1'b1; push_data = 16'h1111 * 16'(k + 1);
            tick();
        end
        check("R2 full after four", fifo_full, 1);
        check("R2 ready low", push_ready, 0);
        push_data = 16'h5555;
        tick();
        push_valid = 1'b0;
        check("R2 still full", fifo_full, 1);
        slot_grant = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R9 cram_we", cram_we, 1);
            check("R9 order data", cram_wdata, 16'h1111 * 16'(k + 1));
            check("R9 order addr", cram_addr, k);
            if (k == 0) check("R2 ready after retire", push_ready, 1);
        end
        check("R2 overfill dropped", fifo_empty, 1);
        check("R10 flag clear before idle", slot_unused, 0);
        tick();
        slot_grant = 1'b0;
        check("R10 idle no write", cram_we, 0);
        check("R10 idle flag", slot_unused, 1);
        tick();
        check("R10 flag sticky", slot_unused, 1);
        unused_clr = 1'b1;
        tick();
        unused_clr = 1'b0;
        check("R10 flag cleared", slot_unused, 0);

        // R10: push and grant in the same cycle
        push_valid = 1'b1; push_data = 16'h6789; slot_grant = 1'b1;
        tick();
        push_valid = 1'b0; slot_grant = 1'b0;
        check("R10 same-cycle no write", cram_we, 0);
        check("R10 same-cycle flag", slot_unused, 1);
        check("R10 word queued", fifo_empty, 0);
        slot_grant = 1'b1;
        tick();
        slot_grant = 1'b0;
        check("R10 served later", cram_wdata, 16'h6789);
        check("R10 served strobe", cram_we, 1);
        check("R10 served addr", cram_addr, 6'h04);

        // R11: load beats the advance
        push_valid = 1'b1; push_data = 16'h4242;
        tick();
        push_valid = 1'b0;
        addr_load = 1'b1; addr_value = 16'h0030; slot_grant = 1'b1;
        tick();
        addr_load = 1'b0; slot_grant = 1'b0;
        check("R11 load wins", cur_addr, 16'h0030);
        check("R11 old addr used", cram_addr, 6'h05);

        // R1: reset mid-run drops queued words
        push_valid = 1'b1; push_data = 16'h0101;
        tick();
        tick();
        push_valid = 1'b0;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R1 reset empties", fifo_empty, 1);
        check("R1 reset addr", cur_addr, 0);
        check("R1 reset flag", slot_unused, 0);

        done = 1'b1;
        finish_run();
    end

endmodule